// File: doc/BRIEF.md
# Interprocessor Interrupt Doorbell

This block lets a host processor raise interrupt requests toward a DSP core through a single 32-bit memory-mapped register. The register holds 28 request lines in its upper bits. A host write can only set lines: each 1 in the line field raises that line's request, and each 0 leaves the line as it was. A write counts only when its lowest bit, a lock/strobe bit, is also 1. A write with that bit at 0 is dropped entirely.

Each pending request drives one level-sensitive interrupt output toward the DSP. The DSP clears requests with a 28-bit acknowledge mask, and a clear takes effect at the clock edge on which the mask is presented. When a host read returns the register, it shows which requests are still pending, so the host can poll until the DSP has handled an interrupt.

Top module: `ipc_doorbell`

## Requirements
- R1: Under synchronous active-high reset every pending bit is 0, so `dspIrq` is all zeros and `hostRdData` is zero. A write presented during reset is ignored.
- R2: A write with `hostWrData[0]` = 1 ORs `hostWrData[n+4]` into pending line n, for n from 0 to 27.
- R3: A write with `hostWrData[0]` = 0 changes no pending bit.
- R4: A 0 in any line bit of a write leaves that line's pending state unchanged, so the host cannot clear a request.
- R5: Each set bit n of `dspAck` clears pending line n at the next clock edge. Lines whose mask bit is 0 are left untouched.
- R6: If a valid write sets line n in the same cycle that `dspAck[n]` clears it, the set wins and the line stays pending.
- R7: `hostRdData[31:4]` returns the pending vector, with line n at bit n+4, and `hostRdData[3:0]` always reads 0.
- R8: `dspIrq[n]` is a level equal to pending line n. It changes one clock edge after the write or acknowledge that causes the change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWrEn | input | 1 | Host write strobe for the doorbell register |
| hostWrData | input | 32 | Host write data: bit 0 is the lock/strobe bit, bits 31:4 are the set mask |
| hostRdData | output | 32 | Live pending status: bits 31:4 are the lines, bits 3:0 read 0 |
| dspAck | input | 28 | DSP acknowledge clear mask, one bit per line |
| dspIrq | output | 28 | Interrupt request levels toward the DSP |

## Verification
The bench walks every line through set, acknowledge, lock-less write and set-against-clear collision. It keeps an arithmetic model of the pending vector to predict the outputs.

Several design errors are aimed at directly:
- An off-by-one in the bit-to-line mapping would light the wrong output on the single-line sweep.
- Treating the write as a plain store would clear lines when later writes carry zeros.
- Ignoring the lock bit would raise lines on writes that should be dropped.
- Letting the clear win would lose a collision case.
- A combinational path from the write to `dspIrq` would show up in the check taken just before each edge.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;
  localparam int REG_W     = 32;
  localparam int LINE_LSB  = 4;
  localparam int NUM_LINES = REG_W - LINE_LSB;
  localparam int LOCK_BIT  = 0;

  typedef struct packed {
    logic setEn;   // valid host write: OR the mask into pending
    logic clrEn;   // DSP acknowledge present: clear masked lines
  } doorbellCtl_t;
endpackage

// File: rtl/ipc_doorbell_ctrl.sv
module ipc_doorbell_ctrl
  import ipc_doorbell_pkg::*;
#(
  parameter int LINES = NUM_LINES
) (
  input  logic             rst,
  input  logic             hostWrEn,
  input  logic             lockBit,
  input  logic [LINES-1:0] dspAck,
  output doorbellCtl_t     ctl
);
  always_comb begin
    ctl.setEn = hostWrEn && lockBit && !rst;
    ctl.clrEn = (|dspAck) && !rst;
  end
endmodule

// File: rtl/ipc_doorbell_dp.sv
module ipc_doorbell_dp
  import ipc_doorbell_pkg::*;
#(
  parameter int LINES = NUM_LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  doorbellCtl_t     ctl,
  input  logic [LINES-1:0] setMask,
  input  logic [LINES-1:0] clrMask,
  output logic [LINES-1:0] pending
);
  logic [LINES-1:0] pendingNext;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic setHit;
    logic clrHit;
    assign setHit = ctl.setEn && setMask[n];
    assign clrHit = ctl.clrEn && clrMask[n];
    always_comb begin
      if (setHit)      pendingNext[n] = 1'b1;   // set wins over clear
      else if (clrHit) pendingNext[n] = 1'b0;
      else             pendingNext[n] = pending[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= pendingNext;
  end
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipc_doorbell_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hostWrEn,
  input  logic [REG_W-1:0]     hostWrData,
  output logic [REG_W-1:0]     hostRdData,
  input  logic [NUM_LINES-1:0] dspAck,
  output logic [NUM_LINES-1:0] dspIrq
);
  doorbellCtl_t         ctl;
  logic [NUM_LINES-1:0] pending;

  ipc_doorbell_ctrl #(.LINES(NUM_LINES)) ctrl_i (
    .rst      (rst),
    .hostWrEn (hostWrEn),
    .lockBit  (hostWrData[LOCK_BIT]),
    .dspAck   (dspAck),
    .ctl      (ctl)
  );

  ipc_doorbell_dp #(.LINES(NUM_LINES)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .setMask (hostWrData[REG_W-1:LINE_LSB]),
    .clrMask (dspAck),
    .pending (pending)
  );

  assign hostRdData = {pending, {LINE_LSB{1'b0}}};
  assign dspIrq     = pending;
endmodule

// File: rtl/ipc_doorbell_chk.sv
module ipc_doorbell_chk
  import ipc_doorbell_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 hostWrEn,
  input logic [REG_W-1:0]     hostWrData,
  input logic [REG_W-1:0]     hostRdData,
  input logic [NUM_LINES-1:0] dspAck,
  input logic [NUM_LINES-1:0] dspIrq
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (dspIrq == '0)); // R1

  AST_SET_LINES: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && hostWrData[LOCK_BIT]) |=>
      ((dspIrq & $past(hostWrData[REG_W-1:LINE_LSB])) == $past(hostWrData[REG_W-1:LINE_LSB]))); // R2

  AST_LOCKLESS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hostWrEn && !hostWrData[LOCK_BIT] && dspAck == '0) |=> $stable(dspIrq)); // R3

  AST_NO_HOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dspAck == '0) |=> ((dspIrq & $past(dspIrq)) == $past(dspIrq))); // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dspAck != '0 && !(hostWrEn && hostWrData[LOCK_BIT])) |=>
      ((dspIrq & $past(dspAck)) == '0)); // R5

  AST_READ_LOW_ZERO: assert property (@(posedge clk) hostRdData[LINE_LSB-1:0] == '0); // R7

  AST_READ_MATCHES_IRQ: assert property (@(posedge clk)
    hostRdData[REG_W-1:LINE_LSB] == dspIrq); // R8
endmodule

bind ipc_doorbell ipc_doorbell_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .hostWrEn   (hostWrEn),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .dspAck     (dspAck),
  .dspIrq     (dspIrq)
);

// File: tb/ipc_doorbell_tb.sv
`timescale 1ns/1ps
module ipc_doorbell_tb_top;
  localparam int W = 32;
  localparam int L = 28;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         hostWrEn = 1'b0;
  logic [W-1:0] hostWrData = '0;
  logic [W-1:0] hostRdData;
  logic [L-1:0] dspAck = '0;
  logic [L-1:0] dspIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [L-1:0] model = '0;

  always #2.5 clk = ~clk;

  ipc_doorbell dut_i (
    .clk(clk), .rst(rst), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .dspAck(dspAck), .dspIrq(dspIrq)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a negedge, verify that nothing moves before the edge (R8),
  // then update the model and check both outputs after the edge (R7, R8).
  task automatic step(input string tag, input logic wr, input logic [W-1:0] data,
                      input logic [L-1:0] ack);
    logic [L-1:0] setM;
    hostWrEn = wr; hostWrData = data; dspAck = ack;
    #1;
    check({tag, " R8 no early change"}, {4'h0, dspIrq}, {4'h0, model});
    @(posedge clk);
    setM  = (wr && data[0]) ? data[W-1:4] : '0;
    model = (model & ~ack) | setM;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0; dspAck = '0;
    check({tag, " R8 irq"}, {4'h0, dspIrq}, {4'h0, model});
    check({tag, " R7 read"}, hostRdData, {model, 4'h0});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset with a write attempt held during reset
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = 32'hFFFF_FFF1; dspAck = '0;
    repeat (3) @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
    check("R1 irq reset", {4'h0, dspIrq}, 32'h0);
    check("R1 read reset", hostRdData, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R2 and R5: each line set alone, then acknowledged alone
    for (int n = 0; n < L; n++) begin
      step("R2 single set", 1'b1, (32'h1 << (n + 4)) | 32'h1, '0);
      check("R2 one-hot line", {4'h0, dspIrq}, 32'h1 << n);
      step("R5 single ack", 1'b0, '0, 28'h1 << n);
      check("R5 cleared", {4'h0, dspIrq}, 32'h0);
    end

    // R3: each line written without the lock bit is dropped
    for (int n = 0; n < L; n++) begin
      step("R3 lockless", 1'b1, 32'h1 << (n + 4), '0);
      check("R3 still idle", {4'h0, dspIrq}, 32'h0);
    end
    // R7: low bits written alongside the lock bit do nothing visible
    step("R7 low bits", 1'b1, 32'h0000_000F, '0);

    // R4: zeros never clear, the OR accumulates patterns
    step("R4 pattern a", 1'b1, 32'hA5A5_A5A1, '0);
    step("R4 zero write", 1'b1, 32'h0000_0001, '0);
    check("R4 kept", {4'h0, dspIrq}, {4'h0, 28'hA5A5A5A});
    step("R4 pattern b", 1'b1, 32'h5A5A_5A51, '0);
    check("R4 all set", {4'h0, dspIrq}, {4'h0, 28'hFFFFFFF});
    step("R3 lockless zeros", 1'b1, 32'h0000_0000, '0);

    // R5: partial masks leave other lines pending
    step("R5 partial ack", 1'b0, '0, 28'h0F0F0F0);
    check("R5 partial", {4'h0, dspIrq}, {4'h0, 28'hF0F0F0F});
    step("R5 ack rest", 1'b0, '0, 28'hFFFFFFF);

    // R6: set against full clear in the same cycle, per line
    for (int n = 0; n < L; n++) begin
      step("R6 collision", 1'b1, (32'h1 << (n + 4)) | 32'h1, 28'hFFFFFFF);
      check("R6 set wins", {4'h0, dspIrq}, 32'h1 << n);
    end
    // R6 lockless write does not protect against a clear
    step("R6 lockless vs ack", 1'b1, 32'hFFFF_FFF0, 28'hFFFFFFF);
    check("R6 cleared", {4'h0, dspIrq}, 32'h0);

    // R1: reset again from a busy state
    step("R2 refill", 1'b1, 32'hFFFF_FFF1, '0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; model = '0;
    check("R1 reset busy", hostRdData, 32'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule